// File: doc/BRIEF.md
# Message Block Byte Receiver

This block collects the message bytes that a host streams over an 8-bit parallel bus and packs them into 64-byte blocks for a downstream hash compression engine. Every byte carries a valid strobe and a 2-bit command code. Two of the codes mark message data and the other two mark configuration traffic. Configuration bytes share the bus but are handled elsewhere, so this block drops them. Bytes enter a chain of byte registers. Each accepted byte moves the whole chain along by one lane. No addressed write takes place. A small index counter is used only to recognise that the 64th byte has arrived.

When a block completes, the receiver pulses a done strobe and lowers its ready output. It then holds the buffer stable until the engine reports that it has finished reading it. The host may stream the next block only while ready is high. The host may leave idle cycles of any length between bytes. The receiver also keeps the 64-bit byte offset that the engine needs. The offset advances by one block for each ordinary block. On the final block of a message it takes the total message length instead. It returns to zero once the engine has released a final block.

Top module: `msg_block_rx`

## Requirements
- R1: After reset, hostReady is 1, blkDone is 0, blkLast is 0, byteOffset is 0 and blkData is all zeros.
- R2: A byte is accepted when inValid is 1, hostReady is 1 and inCmd is 2'b00 (data) or 2'b01 (final data). In a completed block, the k-th accepted byte (k = 0..63, first byte k = 0) sits at blkData[8k+7:8k].
- R3: blkDone is high for exactly one cycle. That cycle directly follows the clock edge that accepts the 64th byte of a block. blkDone is low at all other times.
- R4: Cycles with inValid low, at any point inside a block, neither advance the byte count nor alter blkData.
- R5: Bytes with inCmd 2'b10 or 2'b11 (configuration) are ignored. They do not count toward the block and do not enter blkData.
- R6: hostReady falls in the same cycle that blkDone rises. While hostReady is low, valid data bytes are ignored and blkData holds its value.
- R7: A one-cycle engRelease pulse while hostReady is low raises hostReady in the next cycle. An engRelease while hostReady is high has no effect. A data byte offered in the same cycle as the engRelease is dropped.
- R8: When a block completes with 2'b00 on its 64th byte, byteOffset increases by 64 and blkLast is 0. Both values are visible in the blkDone cycle.
- R9: When a block completes with 2'b01 on its 64th byte, byteOffset becomes totalLen as sampled with that byte, and blkLast is 1. Both values are visible in the blkDone cycle.
- R10: An engRelease that ends a final block (blkLast = 1) clears byteOffset to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte strobe from the host |
| inCmd | input | 2 | Byte kind: 00 data, 01 final data, 10/11 configuration |
| inByte | input | 8 | Byte from the host |
| totalLen | input | 64 | Total message length in bytes, used on a final block |
| engRelease | input | 1 | Engine has finished reading the buffer |
| hostReady | output | 1 | Host may stream a block |
| blkDone | output | 1 | One-cycle pulse when a block is complete |
| blkLast | output | 1 | Completed block was the final one |
| blkData | output | 512 | Assembled block, byte 0 in the low bits |
| byteOffset | output | 64 | Running byte offset for the engine |

## Verification
Two events can land on the same edge: the engine's release of the buffer and the host offering a data byte. The release reopens ready one cycle later, so a byte that arrives with it must be lost. The bench provokes this on purpose after every block by driving a valid data byte in the release cycle. The result is then judged at the ports. blkData must be unchanged after that edge. The next block must also complete on exactly its own 64th byte, with contents that do not include the dropped byte. Release pulses during active streaming and configuration bytes inside gaps are mixed in at random. They are judged the same way, through the done timing and the block contents.

// File: rtl/msg_block_rx_pkg.sv
package msg_block_rx_pkg;
  typedef enum logic [1:0] {
    CMD_DATA  = 2'b00,
    CMD_FINAL = 2'b01,
    CMD_CFGA  = 2'b10,
    CMD_CFGB  = 2'b11
  } rx_cmd_e;

  typedef struct packed {
    logic shiftEn;
    logic bumpOffs;
    logic loadLen;
    logic clrOffs;
  } rx_strobe_t;
endpackage

// File: rtl/msg_block_rx_ctrl.sv
module msg_block_rx_ctrl
  import msg_block_rx_pkg::*;
#(
  parameter int BLK_BYTES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inCmd,
  input  logic       engRelease,
  output rx_strobe_t strobe,
  output logic       hostReady,
  output logic       blkDone,
  output logic       blkLast
);
  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  logic [IDX_W-1:0] byteIdx;
  logic isData, accept, finishing, freeing;

  assign isData    = (inCmd == CMD_DATA) || (inCmd == CMD_FINAL);
  assign accept    = inValid && hostReady && isData;
  assign finishing = accept && (byteIdx == LAST_IDX);
  assign freeing   = engRelease && !hostReady;

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = accept;
    strobe.bumpOffs = finishing && (inCmd == CMD_DATA);
    strobe.loadLen  = finishing && (inCmd == CMD_FINAL);
    strobe.clrOffs  = freeing && blkLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx   <= '0;
      hostReady <= 1'b1;
      blkDone   <= 1'b0;
      blkLast   <= 1'b0;
    end else begin
      blkDone <= finishing;
      if (accept) byteIdx <= finishing ? '0 : byteIdx + 1'b1;
      if (finishing) begin
        hostReady <= 1'b0;
        blkLast   <= (inCmd == CMD_FINAL);
      end else if (freeing) begin
        hostReady <= 1'b1;
      end
    end
  end

  // R3: the done pulse never lasts two cycles
  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |=> !blkDone);
  // R6: ready is low whenever done is shown
  a_r6_ready_low_on_done: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |-> !hostReady);
  // R4: an idle cycle leaves the byte count alone
  a_r4_idle_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(byteIdx));
  // R7: a release while busy reopens the host port
  a_r7_release_reopens: assert property (@(posedge clk) disable iff (!rstN)
    (engRelease && !hostReady) |=> hostReady);
  // R9: the offset strobes never collide
  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.bumpOffs, strobe.loadLen, strobe.clrOffs}));
endmodule

// File: rtl/msg_block_rx_datapath.sv
module msg_block_rx_datapath
  import msg_block_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int BLK_BYTES = 64,
  parameter int OFFS_W    = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rx_strobe_t                  strobe,
  input  logic [BYTE_W-1:0]           inByte,
  input  logic [OFFS_W-1:0]           totalLen,
  output logic [BYTE_W*BLK_BYTES-1:0] blkData,
  output logic [OFFS_W-1:0]           byteOffset
);
  localparam logic [OFFS_W-1:0] BLK_STEP = OFFS_W'(BLK_BYTES);

  logic [BYTE_W-1:0] lane [BLK_BYTES];

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] feed;
    if (i == BLK_BYTES - 1) begin : g_head
      assign feed = inByte;
    end else begin : g_body
      assign feed = lane[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rstN)               lane[i] <= '0;
      else if (strobe.shiftEn) lane[i] <= feed;
    end
    assign blkData[i*BYTE_W +: BYTE_W] = lane[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                byteOffset <= '0;
    else if (strobe.loadLen)  byteOffset <= totalLen;
    else if (strobe.bumpOffs) byteOffset <= byteOffset + BLK_STEP;
    else if (strobe.clrOffs)  byteOffset <= '0;
  end

  // R6: without a shift strobe the buffer holds still
  a_r6_hold_without_shift: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(blkData));
  // R8: an ordinary block moves the offset by one block
  a_r8_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bumpOffs |=> (byteOffset == $past(byteOffset) + BLK_STEP));
  // R10: clearing leaves zero
  a_r10_offset_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrOffs |=> (byteOffset == '0));
endmodule

// File: rtl/msg_block_rx.sv
module msg_block_rx
  import msg_block_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int BLK_BYTES = 64,
  parameter int OFFS_W    = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [1:0]                  inCmd,
  input  logic [BYTE_W-1:0]           inByte,
  input  logic [OFFS_W-1:0]           totalLen,
  input  logic                        engRelease,
  output logic                        hostReady,
  output logic                        blkDone,
  output logic                        blkLast,
  output logic [BYTE_W*BLK_BYTES-1:0] blkData,
  output logic [OFFS_W-1:0]           byteOffset
);
  rx_strobe_t strobe;

  msg_block_rx_ctrl #(.BLK_BYTES(BLK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCmd(inCmd),
    .engRelease(engRelease), .strobe(strobe), .hostReady(hostReady),
    .blkDone(blkDone), .blkLast(blkLast)
  );

  msg_block_rx_datapath #(.BYTE_W(BYTE_W), .BLK_BYTES(BLK_BYTES), .OFFS_W(OFFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(inByte),
    .totalLen(totalLen), .blkData(blkData), .byteOffset(byteOffset)
  );
endmodule

// File: tb/msg_block_rx_bench.sv
module msg_block_rx_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   inCmd = 2'b00;
  logic [7:0]   inByte = 8'h00;
  logic [63:0]  totalLen = 64'd0;
  logic         engRelease = 1'b0;
  logic         hostReady, blkDone, blkLast;
  logic [511:0] blkData;
  logic [63:0]  byteOffset;

  int total = 0;
  int bad = 0;
  logic [7:0]   blkBytes [64];
  logic [511:0] expData = '0;
  logic [63:0]  expOffs = '0;
  logic         expLast = 1'b0;

  always #4 clk = ~clk;

  msg_block_rx u_msg_block_rx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCmd(inCmd), .inByte(inByte),
    .totalLen(totalLen), .engRelease(engRelease), .hostReady(hostReady),
    .blkDone(blkDone), .blkLast(blkLast), .blkData(blkData), .byteOffset(byteOffset)
  );

  function automatic logic [511:0] packBlock();
    logic [511:0] v;
    for (int k = 0; k < 64; k++) v[8*k +: 8] = blkBytes[k];
    return v;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    inValid = 1'b0; inCmd = 2'b00; inByte = 8'h00; engRelease = 1'b0;
  endtask

  // Streams one block with random gaps; gaps may carry config bytes or stray releases
  task automatic sendBlock(input bit isFinal, input int gapPct, input int cfgPct);
    for (int k = 0; k < 64; k++) blkBytes[k] = 8'($urandom);
    for (int k = 0; k < 64; k++) begin
      while (int'($urandom % 100) < gapPct) begin
        @(negedge clk);
        check("R3 no early done", {511'd0, blkDone}, 512'd0);
        idle();
        if (int'($urandom % 100) < cfgPct) begin
          inValid = 1'b1; inCmd = 2'($urandom % 2) | 2'b10; inByte = 8'($urandom); // R5
        end
        engRelease = ($urandom % 8 == 0); // R7 release while ready high is ignored
      end
      @(negedge clk);
      check("R3 no early done", {511'd0, blkDone}, 512'd0);
      idle();
      inValid = 1'b1;
      inCmd = (k == 63 && isFinal) ? 2'b01 : 2'b00;
      inByte = blkBytes[k];
    end
    expData = packBlock();
    expLast = isFinal;
    expOffs = isFinal ? totalLen : expOffs + 64'd64;
    @(negedge clk);
    idle();
    check("R3 done after 64th byte", {511'd0, blkDone}, 512'd1);
    check("R6 ready low on done", {511'd0, hostReady}, 512'd0);
    check("R2 R4 R5 block contents", blkData, expData);
    check(isFinal ? "R9 last flag" : "R8 last flag", {511'd0, blkLast}, {511'd0, expLast});
    check(isFinal ? "R9 offset load" : "R8 offset step", {448'd0, byteOffset}, {448'd0, expOffs});
    @(negedge clk);
    check("R3 done one cycle", {511'd0, blkDone}, 512'd0);
  endtask

  // Busy phase: bytes while busy are ignored; one byte rides with the release
  task automatic busyRelease(input int nBytes);
    for (int n = 0; n < nBytes; n++) begin
      idle(); inValid = 1'b1; inCmd = 2'($urandom % 2); inByte = 8'($urandom);
      @(negedge clk);
      check("R6 held while busy", blkData, expData);
      check("R6 ready stays low", {511'd0, hostReady}, 512'd0);
    end
    idle();
    engRelease = 1'b1; inValid = 1'b1; inCmd = 2'b00; inByte = 8'hAA;
    @(negedge clk);
    idle();
    if (expLast) expOffs = '0;
    check("R7 ready back", {511'd0, hostReady}, 512'd1);
    check("R7 same-cycle byte dropped", blkData, expData);
    check(expLast ? "R10 offset cleared" : "R8 offset kept", {448'd0, byteOffset}, {448'd0, expOffs});
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 ready", {511'd0, hostReady}, 512'd1);
    check("R1 done", {511'd0, blkDone}, 512'd0);
    check("R1 last", {511'd0, blkLast}, 512'd0);
    check("R1 offset", {448'd0, byteOffset}, 512'd0);
    check("R1 data", blkData, 512'd0);
    rstN = 1'b1;
    // directed: back-to-back bytes, no gaps
    sendBlock(1'b0, 0, 0);
    busyRelease(3);
    // directed: long gaps full of config bytes
    sendBlock(1'b0, 70, 90);
    busyRelease(1);
    // directed: final block with a chosen length
    totalLen = 64'h0000_0001_0000_00BD;
    sendBlock(1'b1, 30, 50);
    busyRelease(2);
    // random messages
    for (int m = 0; m < 6; m++) begin
      int nb;
      nb = 1 + int'($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        totalLen = {32'd0, $urandom};
        sendBlock(b == nb - 1, int'($urandom % 60), int'($urandom % 100));
        busyRelease(int'($urandom % 4));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule